// File: doc/BRIEF.md
# Supply fault protection sequencer

This block sequences the protection response of one regulated supply output. External comparators report overcurrent, reverse (backward) current and over-temperature as synchronous level flags. A millisecond tick paces every timer. From these the block decides when the power stage may run, and when a soft-start ramp must be requested. It also raises per-fault status bits and drives an active-low fault line.

In dynamic current-limit mode, a persistent overload is handled by hiccup operation: a bounded on time, then a long off time, then a fresh soft-start. A reverse current is handled with its own short on window and off window. In static current-limit mode the output keeps running and only a flag reports the clamp. Over-temperature shuts the output down until the flag clears. After a fixed number of such events the shutdown becomes permanent until the enable is dropped and raised again. All windows are counted in ticks, so a test can scale time by pacing the tick.

Top module: `supply_prot_seq`

## Requirements
- R1: After reset or with `en` low, `pwr_en`, `ss_req`, `olf`, `bcf` and `otf` are 0 and `flt_n` is 1 unless `uvlo` or `if_reset` is high. One clock after `en` is sampled high, `pwr_en` and `ss_req` are 1. `ss_req` stays 1 until `ss_done` is sampled high, and then falls on the next clock with `pwr_en` still 1.
- R2: With `dcl`=0, an `oc_flag` held while the output is powered turns the output off once OC_ON_MS ticks have been counted. Starting from the run state with a tick every clock, `pwr_en` stays 1 for exactly OC_ON_MS cycles after `oc_flag` rises. During the off window `olf`=1 and `flt_n`=0.
- R3: An `oc_flag` that drops before OC_ON_MS ticks are counted clears the count. `olf` stays 0 and the output stays on.
- R4: The overload off window ends on the first clock after OC_OFF_MS ticks are counted (OC_OFF_MS+1 cycles with a tick every clock). `olf` then clears and a soft-start begins. If the overload persists, the on window runs again from zero (OC_ON_MS+1 cycles when the flag was already high at entry).
- R5: With `dcl`=1 the output is never shut down for overcurrent. `olf` rises one clock after `oc_flag` is sampled while powered, stays high after the flag drops, and clears one clock after `ss_done` is sampled in soft-start.
- R6: A `bc_flag` held for BC_ON_MS ticks while powered turns the output off for BC_OFF_MS ticks with `bcf`=1. This does not drive `flt_n` low. At the end of the window a soft-start follows, and the cycle repeats while the flag persists.
- R7: `ot_flag` sampled while enabled and not already in a thermal state turns the output off on the next clock with `otf`=1 and `flt_n`=0. When `ot_flag` is sampled low, soft-start resumes and `otf` clears.
- R8: The OT_LATCH_COUNT-th thermal event since `en` last rose latches the output off with `otf`=1 and `flt_n`=0, even after `ot_flag` clears. Sampling `en` low clears both the latch and the event count.
- R9: `flt_n` is 0 whenever `uvlo` or `if_reset` is high, combinationally.
- R10: Over-temperature takes precedence over current faults in the same cycle. Of the three status bits, at most one is high at a time.
- R11: `en` sampled low forces the output off with all status bits cleared on the next clock, from any state.
- R12: Timers advance only on clocks with `ms_tick` high. With no tick, a held overcurrent never trips. With a tick on alternate clocks, the run-state on window is 2·OC_ON_MS−1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-clock pulse per millisecond |
| en | input | 1 | Output enable |
| dcl | input | 1 | 1 = static current limit, 0 = dynamic (hiccup) limit |
| oc_flag | input | 1 | Overcurrent comparator level |
| bc_flag | input | 1 | Backward-current comparator level |
| ot_flag | input | 1 | Over-temperature comparator level (hysteresis external) |
| ss_done | input | 1 | Soft-start ramp complete |
| uvlo | input | 1 | Undervoltage lockout active |
| if_reset | input | 1 | Control interface in reset |
| pwr_en | output | 1 | Power stage enable |
| ss_req | output | 1 | Soft-start request |
| olf | output | 1 | Overload status |
| bcf | output | 1 | Backward-current status |
| otf | output | 1 | Over-temperature status |
| flt_n | output | 1 | Active-low fault line |

## Verification
The assertions treat every input as a synchronous level that changes only between clock edges. The one exception is `uvlo`/`if_reset`, which reach `flt_n` through logic alone and are checked in the same cycle. The thermal-response and disable properties assume `ot_flag` and `en` are sampled at the edge that starts the transition. They make no assumption about how long a flag is held. The stimulus drives all inputs on the falling edge. It holds `ss_done` only for single pulses, and keeps `ms_tick` at one pulse per clock except in the scaling test, so every window length has a single expected cycle count.

// File: rtl/prot_pkg.sv
package prot_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_SOFT,
    ST_RUN,
    ST_OC_OFF,
    ST_BC_OFF,
    ST_OT_OFF,
    ST_OT_LATCH
  } prot_state_e;
endpackage

// File: rtl/prot_ms_timer.sv
module prot_ms_timer #(
  parameter int LIMIT = 51
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (!run)               cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);
endmodule

// File: rtl/prot_event_counter.sv
module prot_event_counter #(
  parameter int COUNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic hit,
  output logic last
);
  localparam int W = $clog2(COUNT + 1);
  localparam logic [W-1:0] TOP  = W'(COUNT);
  localparam logic [W-1:0] LAST = W'(COUNT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (hit && cnt != TOP) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == LAST);
endmodule

// File: rtl/supply_prot_seq.sv
module supply_prot_seq
  import prot_pkg::*;
#(
  parameter int OC_ON_MS       = 51,
  parameter int OC_OFF_MS      = 900,
  parameter int BC_ON_MS       = 2,
  parameter int BC_OFF_MS      = 50,
  parameter int OT_LATCH_COUNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic en,
  input  logic dcl,
  input  logic oc_flag,
  input  logic bc_flag,
  input  logic ot_flag,
  input  logic ss_done,
  input  logic uvlo,
  input  logic if_reset,
  output logic pwr_en,
  output logic ss_req,
  output logic olf,
  output logic bcf,
  output logic otf,
  output logic flt_n
);
  prot_state_e state_q, state_d;

  logic powered, in_oc_off, in_bc_off, in_thermal;
  logic oc_run, bc_run;
  logic oc_trip, bc_trip, oc_off_done, bc_off_done;
  logic ot_enter, ot_last;
  logic static_olf_q;

  assign powered    = (state_q == ST_SOFT) || (state_q == ST_RUN);
  assign in_oc_off  = (state_q == ST_OC_OFF);
  assign in_bc_off  = (state_q == ST_BC_OFF);
  assign in_thermal = (state_q == ST_OT_OFF) || (state_q == ST_OT_LATCH);

  assign oc_run   = oc_flag & ~dcl & powered;
  assign bc_run   = bc_flag & powered;
  assign ot_enter = en & ot_flag & (powered | in_oc_off | in_bc_off);

  // on-window timers (fault must persist) and off-window timers
  prot_ms_timer #(.LIMIT(OC_ON_MS)) u_oc_on (
    .clk(clk), .rst_n(rst_n), .run(oc_run), .tick(ms_tick), .done(oc_trip));
  prot_ms_timer #(.LIMIT(BC_ON_MS)) u_bc_on (
    .clk(clk), .rst_n(rst_n), .run(bc_run), .tick(ms_tick), .done(bc_trip));
  prot_ms_timer #(.LIMIT(OC_OFF_MS)) u_oc_off (
    .clk(clk), .rst_n(rst_n), .run(in_oc_off), .tick(ms_tick), .done(oc_off_done));
  prot_ms_timer #(.LIMIT(BC_OFF_MS)) u_bc_off (
    .clk(clk), .rst_n(rst_n), .run(in_bc_off), .tick(ms_tick), .done(bc_off_done));

  prot_event_counter #(.COUNT(OT_LATCH_COUNT)) u_ot_cnt (
    .clk(clk), .rst_n(rst_n), .clr(~en), .hit(ot_enter), .last(ot_last));

  always_comb begin
    state_d = state_q;
    if (!en) begin
      state_d = ST_OFF;
    end else if (ot_enter) begin
      state_d = ot_last ? ST_OT_LATCH : ST_OT_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:    state_d = ST_SOFT;
        ST_SOFT, ST_RUN: begin
          if (oc_trip)                           state_d = ST_OC_OFF;
          else if (bc_trip)                      state_d = ST_BC_OFF;
          else if (state_q == ST_SOFT && ss_done) state_d = ST_RUN;
        end
        ST_OC_OFF: if (oc_off_done) state_d = ST_SOFT;
        ST_BC_OFF: if (bc_off_done) state_d = ST_SOFT;
        ST_OT_OFF: if (!ot_flag)    state_d = ST_SOFT;
        default:   state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  // static-mode clamp flag: set by overcurrent, cleared at end of soft-start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) static_olf_q <= 1'b0;
    else        static_olf_q <= powered && !(state_q == ST_SOFT && ss_done) &&
                                (static_olf_q || (dcl && oc_flag));
  end

  assign pwr_en = powered;
  assign ss_req = (state_q == ST_SOFT);
  assign olf    = in_oc_off | (static_olf_q & powered);
  assign bcf    = in_bc_off;
  assign otf    = in_thermal;
  assign flt_n  = ~(in_oc_off | in_thermal | uvlo | if_reset);
endmodule

// File: rtl/prot_seq_checker.sv
module prot_seq_checker (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic ot_flag,
  input logic uvlo,
  input logic if_reset,
  input logic pwr_en,
  input logic ss_req,
  input logic olf,
  input logic bcf,
  input logic otf,
  input logic flt_n
);
  assert_disable_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pwr_en && !olf && !bcf && !otf));

  assert_soft_is_powered_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ss_req |-> pwr_en);

  assert_bc_window_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bcf |-> !pwr_en);

  assert_thermal_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    otf |-> (!pwr_en && !flt_n));

  assert_ot_response_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ot_flag && pwr_en) |=> otf);

  assert_ext_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (uvlo || if_reset) |-> !flt_n);

  assert_one_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({olf, bcf, otf}));
endmodule

bind supply_prot_seq prot_seq_checker u_prot_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .ot_flag(ot_flag), .uvlo(uvlo),
  .if_reset(if_reset), .pwr_en(pwr_en), .ss_req(ss_req), .olf(olf),
  .bcf(bcf), .otf(otf), .flt_n(flt_n));

// File: tb/sim_supply_prot_seq.sv
module sim_supply_prot_seq;
  localparam int OC_ON = 51, OC_OFF = 900, BC_ON = 2, BC_OFF = 50, OT_N = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, ms_tick = 1'b1, en = 1'b0, dcl = 1'b0;
  logic oc_flag = 1'b0, bc_flag = 1'b0, ot_flag = 1'b0, ss_done = 1'b0;
  logic uvlo = 1'b0, if_reset = 1'b0;
  logic pwr_en, ss_req, olf, bcf, otf, flt_n;

  int checks = 0, errors = 0;
  bit finished = 0;

  supply_prot_seq #(.OC_ON_MS(OC_ON), .OC_OFF_MS(OC_OFF), .BC_ON_MS(BC_ON),
                    .BC_OFF_MS(BC_OFF), .OT_LATCH_COUNT(OT_N)) u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .en(en), .dcl(dcl),
    .oc_flag(oc_flag), .bc_flag(bc_flag), .ot_flag(ot_flag), .ss_done(ss_done),
    .uvlo(uvlo), .if_reset(if_reset), .pwr_en(pwr_en), .ss_req(ss_req),
    .olf(olf), .bcf(bcf), .otf(otf), .flt_n(flt_n));

  // reference model: 0 off,1 soft,2 run,3 overload off,4 backward off,5 thermal off,6 latched
  int ms = 0, occ = 0, bcc = 0, offc = 0, otn = 0;
  bit solf = 0;

  always @(posedge clk or negedge rst_n) begin : model
    int nst, nocc, nbcc, noffc, notn, lim;
    bit pw, nsolf, ent;
    if (!rst_n) begin
      ms = 0; occ = 0; bcc = 0; offc = 0; otn = 0; solf = 0;
    end else begin
      pw  = (ms == 1 || ms == 2);
      lim = (ms == 3) ? OC_OFF : BC_OFF;
      ent = en && ot_flag && (ms >= 1 && ms <= 4);
      nst = ms; notn = otn;
      if (!en) begin
        nst = 0; notn = 0;
      end else if (ent) begin
        nst = (otn == OT_N - 1) ? 6 : 5;
        if (otn < OT_N) notn = otn + 1;
      end else if (ms == 0) nst = 1;
      else if (pw) begin
        if (occ == OC_ON) nst = 3;
        else if (bcc == BC_ON) nst = 4;
        else if (ms == 1 && ss_done) nst = 2;
      end else if (ms == 3 || ms == 4) begin
        if (offc == lim) nst = 1;
      end else if (ms == 5) begin
        if (!ot_flag) nst = 1;
      end
      nocc  = (oc_flag && !dcl && pw) ? ((ms_tick && occ < OC_ON) ? occ + 1 : occ) : 0;
      nbcc  = (bc_flag && pw) ? ((ms_tick && bcc < BC_ON) ? bcc + 1 : bcc) : 0;
      noffc = (ms == 3 || ms == 4) ? ((ms_tick && offc < lim) ? offc + 1 : offc) : 0;
      nsolf = pw && !(ms == 1 && ss_done) && (solf || (dcl && oc_flag));
      ms = nst; occ = nocc; bcc = nbcc; offc = noffc; otn = notn; solf = nsolf;
    end
  end

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic chkn(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  // per-cycle comparison against the model, between edges
  always begin
    @(negedge clk);
    #2;
    if (rst_n && !finished) begin
      chk("R2 model pwr_en", pwr_en, ms == 1 || ms == 2);
      chk("R4 model ss_req", ss_req, ms == 1);
      chk("R5 model olf", olf, ms == 3 || (solf && (ms == 1 || ms == 2)));
      chk("R6 model bcf", bcf, ms == 4);
      chk("R7 model otf", otf, ms == 5 || ms == 6);
      chk("R9 model flt_n", flt_n, !(ms == 3 || ms == 5 || ms == 6 || uvlo || if_reset));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic to_run();
    ss_done = 1'b1; cyc(1); ss_done = 1'b0;
  endtask

  task automatic count_high(output int n);
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (pwr_en) n++; else break;
    end
  endtask

  task automatic count_low(output int n);
    n = 1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (!pwr_en) n++; else break;
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int n;
    cyc(3);
    chk("R1 reset pwr_en", pwr_en, 0); chk("R1 reset ss_req", ss_req, 0);
    chk("R1 reset olf", olf, 0); chk("R1 reset bcf", bcf, 0);
    chk("R1 reset otf", otf, 0); chk("R1 reset flt_n", flt_n, 1);
    rst_n = 1'b1; cyc(2);
    chk("R1 disabled pwr_en", pwr_en, 0);
    en = 1'b1; cyc(1);
    chk("R1 start pwr_en", pwr_en, 1); chk("R1 start ss_req", ss_req, 1);
    cyc(5); chk("R1 soft held", ss_req, 1);
    to_run();
    chk("R1 run ss_req", ss_req, 0); chk("R1 run pwr_en", pwr_en, 1);

    // R3: short overloads
    oc_flag = 1'b1; cyc(40); oc_flag = 1'b0; cyc(1);
    oc_flag = 1'b1; cyc(40); oc_flag = 1'b0; cyc(1);
    chk("R3 short oc olf", olf, 0); chk("R3 short oc pwr_en", pwr_en, 1);

    // R2 / R4: hiccup
    oc_flag = 1'b1;
    count_high(n); chkn("R2 on window", n, OC_ON);
    chk("R2 olf in off", olf, 1); chk("R2 flt_n in off", flt_n, 0);
    count_low(n); chkn("R4 off window", n, OC_OFF + 1);
    chk("R4 olf cleared", olf, 0); chk("R4 soft restart", ss_req, 1);
    count_high(n); n++; chkn("R4 repeat on window", n, OC_ON + 1);
    oc_flag = 1'b0; cyc(OC_OFF + 5); to_run();
    chk("R4 recovered", pwr_en & ~ss_req, 1);

    // R12: tick scaling
    ms_tick = 1'b0; oc_flag = 1'b1; cyc(200);
    chk("R12 no tick pwr_en", pwr_en, 1); chk("R12 no tick olf", olf, 0);
    oc_flag = 1'b0; cyc(1);
    n = 0;
    for (int i = 0; i < 400; i++) begin
      ms_tick = (i % 2 == 0); oc_flag = 1'b1;
      @(negedge clk);
      if (pwr_en) n++; else break;
    end
    chkn("R12 half-rate on window", n, 2 * OC_ON - 1);
    ms_tick = 1'b1; oc_flag = 1'b0; cyc(2 * OC_OFF + 5); to_run();

    // R5: static mode
    dcl = 1'b1; en = 1'b0; cyc(1); en = 1'b1; cyc(1);
    oc_flag = 1'b1; cyc(1);
    chk("R5 static olf set", olf, 1);
    cyc(200);
    chk("R5 static stays on", pwr_en, 1); chk("R5 static olf held", olf, 1);
    oc_flag = 1'b0; cyc(3); chk("R5 olf sticky", olf, 1);
    to_run();
    chk("R5 olf cleared at ss_done", olf, 0); chk("R5 run", ss_req, 0);
    dcl = 1'b0;

    // R6: backward current
    bc_flag = 1'b1;
    count_high(n); chkn("R6 bc on window", n, BC_ON);
    chk("R6 bcf set", bcf, 1); chk("R6 flt_n unaffected", flt_n, 1);
    count_low(n); chkn("R6 bc off window", n, BC_OFF + 1);
    chk("R6 bcf cleared", bcf, 0);
    bc_flag = 1'b0; cyc(1); to_run();

    // R7: thermal event 1
    ot_flag = 1'b1; cyc(1);
    chk("R7 ot pwr off", pwr_en, 0); chk("R7 otf", otf, 1); chk("R7 flt_n", flt_n, 0);
    cyc(10); ot_flag = 1'b0; cyc(1);
    chk("R7 otf cleared", otf, 0); chk("R7 soft resumes", ss_req, 1);
    to_run();

    // R8: events 2..4
    for (int k = 0; k < 2; k++) begin
      ot_flag = 1'b1; cyc(3); ot_flag = 1'b0; cyc(2); to_run();
    end
    ot_flag = 1'b1; cyc(3); ot_flag = 1'b0; cyc(20);
    chk("R8 latched otf", otf, 1); chk("R8 latched off", pwr_en, 0);
    chk("R8 latched flt_n", flt_n, 0);
    en = 1'b0; cyc(1);
    chk("R8 en low clears otf", otf, 0); chk("R11 flt_n released", flt_n, 1);
    en = 1'b1; cyc(1);
    ot_flag = 1'b1; cyc(2); ot_flag = 1'b0; cyc(1);
    chk("R8 count cleared", otf, 0); chk("R8 count cleared soft", ss_req, 1);
    to_run();

    // R9: external fault sources
    uvlo = 1'b1; cyc(1);
    chk("R9 uvlo flt_n", flt_n, 0); chk("R9 uvlo pwr_en", pwr_en, 1);
    uvlo = 1'b0; cyc(1); chk("R9 uvlo release", flt_n, 1);
    if_reset = 1'b1; cyc(1); chk("R9 if_reset flt_n", flt_n, 0);
    if_reset = 1'b0; cyc(1); chk("R9 if_reset release", flt_n, 1);

    // R10: simultaneous faults
    oc_flag = 1'b1; bc_flag = 1'b1; ot_flag = 1'b1; cyc(1);
    chk("R10 ot wins otf", otf, 1); chk("R10 ot wins olf", olf, 0);
    chk("R10 ot wins bcf", bcf, 0);
    cyc(5); ot_flag = 1'b0; cyc(5);
    chk("R10 one status bcf", bcf, 1); chk("R10 one status olf", olf, 0);
    oc_flag = 1'b0; bc_flag = 1'b0; cyc(BC_OFF + 5); to_run();

    // R11: disable from overload off window
    oc_flag = 1'b1; cyc(OC_ON + 5);
    chk("R11 in overload off", olf, 1);
    en = 1'b0; cyc(1);
    chk("R11 pwr_en", pwr_en, 0); chk("R11 olf", olf, 0); chk("R11 flt_n", flt_n, 1);
    oc_flag = 1'b0; en = 1'b1; cyc(1); to_run();
    chk("R11 restart", pwr_en & ~ss_req, 1);

    cyc(3);
    summary();
  end
endmodule